// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block turns a set of already-synchronized input lines into interrupt pulses. The lines are grouped into banks of `BANK_WIDTH` (32 by default). Every line has five pieces of state: an enable (mask) bit, a rising-edge select, a falling-edge select, a sticky pending flag, and a record of the level the line had on the previous clock edge. A level change is found by comparing the present input with that record. The record is refreshed on every clock, whether the line is enabled or not. When an enabled line shows a selected edge, its pending flag is set and its own interrupt output pulses high for exactly one cycle.

Software reaches the per-bank registers through a flat register port. Writes are synchronous and reads are combinational. Pending flags are cleared by writing one to them. A per-bank software-trigger word is kept as plain read/write storage and has no effect on the interrupt logic.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every register of every bank reads zero: enable, rising select, falling select, software word, pending and level record. `irqPulse` is all zeros.
- R2: `regAddr[2:0]` selects the register and the upper bits select the bank. The codes are 0 enable, 1 rising select, 2 falling select, 3 software word (read/write storage), 4 pending (write one to clear), and 5 level record (read-only, writes are ignored). Codes 6 and 7 read as zero. Line n sits in bank n/32 at bit n%32.
- R3: If a line's input equals its recorded level at a clock edge, that line sets no pending flag and produces no pulse.
- R4: The level record follows the input on every clock edge, even while the line is disabled. Enabling a line that is already high therefore causes no interrupt.
- R5: A disabled line (enable bit 0) never sets its pending flag and never pulses, for any edge.
- R6: A 0-to-1 change on an enabled line with its rising select set sets the pending flag and pulses that line's output.
- R7: A 1-to-0 change on an enabled line with its falling select set sets the pending flag and pulses that line's output.
- R8: A rising change with only the falling select set, a falling change with only the rising select set, or any change with neither select set causes no pulse and no pending flag.
- R9: With both selects set, both rising and falling changes trigger.
- R10: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R11: If a qualifying edge and a clear of the same pending bit happen on the same clock edge, the bit ends up set. Other bits cleared by that write still clear.
- R12: `irqPulse` for a line is high for exactly the one cycle that follows the clock edge that detected the edge. The pending flag stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | NUM_BANKS*BANK_WIDTH | Synchronized input lines |
| regAddr | input | BANK_IDX_W+3 | Register address: {bank, register code} |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | BANK_WIDTH | Write data |
| regRdData | output | BANK_WIDTH | Combinational read data for regAddr |
| irqPulse | output | NUM_BANKS*BANK_WIDTH | One-cycle interrupt pulse per line |

## Verification
Two situations are hardest to reach from the ports. The first is a pending clear landing on the same clock edge as a new qualifying edge on that same line. The bench gets there by arming the flag, returning the line low with no falling select, and then, at a single falling clock edge, both raising the line and issuing the write-one clear, so that the register write and the edge meet at one rising edge. The second is level tracking while a line is disabled. The bench toggles a disabled line, reads the level record back, and then enables the line while it is held high, expecting no pulse.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_ENABLE = 3'd0,
    SEL_RISE   = 3'd1,
    SEL_FALL   = 3'd2,
    SEL_SOFT   = 3'd3,
    SEL_PEND   = 3'd4,
    SEL_LEVEL  = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } regSel_e;

  // Write strobes from control to one bank slice
  typedef struct packed {
    logic wrEnable;
    logic wrRise;
    logic wrFall;
    logic wrSoft;
    logic clrPend;
  } bankStb_t;

endpackage

// File: rtl/edge_irq_ctrl_ctl.sv
module edge_irq_ctrl_ctl
  import edge_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_IDX_W = 1,
  parameter int ADDR_W     = BANK_IDX_W + SEL_W
) (
  input  logic                                 regWrEn,
  input  logic [ADDR_W-1:0]                    regAddr,
  output bankStb_t [NUM_BANKS-1:0]             bankStb,
  output logic [BANK_IDX_W-1:0]                rdBank,
  output regSel_e                              rdSel,
  output logic                                 rdHit
);

  logic [BANK_IDX_W-1:0] bankIdx;
  regSel_e               selCode;
  logic                  bankOk;

  assign bankIdx = regAddr[ADDR_W-1:SEL_W];
  assign selCode = regSel_e'(regAddr[SEL_W-1:0]);
  assign bankOk  = (int'(bankIdx) < NUM_BANKS);

  assign rdBank = bankIdx;
  assign rdSel  = selCode;
  assign rdHit  = bankOk;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stb
    logic hit;
    assign hit = regWrEn && bankOk && (int'(bankIdx) == b);
    always_comb begin
      bankStb[b]          = '0;
      bankStb[b].wrEnable = hit && (selCode == SEL_ENABLE);
      bankStb[b].wrRise   = hit && (selCode == SEL_RISE);
      bankStb[b].wrFall   = hit && (selCode == SEL_FALL);
      bankStb[b].wrSoft   = hit && (selCode == SEL_SOFT);
      bankStb[b].clrPend  = hit && (selCode == SEL_PEND);
    end
  end

endmodule

// File: rtl/edge_irq_ctrl_bank.sv
module edge_irq_ctrl_bank
  import edge_irq_pkg::*;
#(
  parameter int BANK_WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BANK_WIDTH-1:0] lineIn,
  input  bankStb_t              stb,
  input  logic [BANK_WIDTH-1:0] wrData,
  output logic [BANK_WIDTH-1:0] enableQ,
  output logic [BANK_WIDTH-1:0] riseQ,
  output logic [BANK_WIDTH-1:0] fallQ,
  output logic [BANK_WIDTH-1:0] softQ,
  output logic [BANK_WIDTH-1:0] pendQ,
  output logic [BANK_WIDTH-1:0] levelQ,
  output logic [BANK_WIDTH-1:0] pulseQ
);

  logic [BANK_WIDTH-1:0] upEdge;
  logic [BANK_WIDTH-1:0] downEdge;
  logic [BANK_WIDTH-1:0] fire;
  logic [BANK_WIDTH-1:0] clrMask;

  // Edge detection against the stored level, not the previous input guess
  assign upEdge   = lineIn & ~levelQ;
  assign downEdge = ~lineIn & levelQ;
  assign fire     = enableQ & ((upEdge & riseQ) | (downEdge & fallQ));
  assign clrMask  = stb.clrPend ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      riseQ   <= '0;
      fallQ   <= '0;
      softQ   <= '0;
      pendQ   <= '0;
      levelQ  <= '0;
      pulseQ  <= '0;
    end else begin
      if (stb.wrEnable) enableQ <= wrData;
      if (stb.wrRise)   riseQ   <= wrData;
      if (stb.wrFall)   fallQ   <= wrData;
      if (stb.wrSoft)   softQ   <= wrData;
      // new edge wins over a simultaneous clear
      pendQ  <= (pendQ & ~clrMask) | fire;
      levelQ <= lineIn;
      pulseQ <= fire;
    end
  end

endmodule

// File: rtl/edge_irq_ctrl_dp.sv
module edge_irq_ctrl_dp
  import edge_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_WIDTH = 32,
  parameter int BANK_IDX_W = 1,
  localparam int NUM_LINES = NUM_BANKS * BANK_WIDTH
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_LINES-1:0]        lineIn,
  input  bankStb_t [NUM_BANKS-1:0]    bankStb,
  input  logic [BANK_WIDTH-1:0]       wrData,
  input  logic [BANK_IDX_W-1:0]       rdBank,
  input  regSel_e                     rdSel,
  input  logic                        rdHit,
  output logic [BANK_WIDTH-1:0]       rdData,
  output logic [NUM_LINES-1:0]        irqPulse
);

  logic [BANK_WIDTH-1:0] enableArr [NUM_BANKS];
  logic [BANK_WIDTH-1:0] riseArr   [NUM_BANKS];
  logic [BANK_WIDTH-1:0] fallArr   [NUM_BANKS];
  logic [BANK_WIDTH-1:0] softArr   [NUM_BANKS];
  logic [BANK_WIDTH-1:0] pendArr   [NUM_BANKS];
  logic [BANK_WIDTH-1:0] levelArr  [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    edge_irq_ctrl_bank #(.BANK_WIDTH(BANK_WIDTH)) bank_i (
      .clk     (clk),
      .rstN    (rstN),
      .lineIn  (lineIn[b*BANK_WIDTH +: BANK_WIDTH]),
      .stb     (bankStb[b]),
      .wrData  (wrData),
      .enableQ (enableArr[b]),
      .riseQ   (riseArr[b]),
      .fallQ   (fallArr[b]),
      .softQ   (softArr[b]),
      .pendQ   (pendArr[b]),
      .levelQ  (levelArr[b]),
      .pulseQ  (irqPulse[b*BANK_WIDTH +: BANK_WIDTH])
    );
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (rdHit && (int'(rdBank) == b)) begin
        unique case (rdSel)
          SEL_ENABLE: rdData = enableArr[b];
          SEL_RISE:   rdData = riseArr[b];
          SEL_FALL:   rdData = fallArr[b];
          SEL_SOFT:   rdData = softArr[b];
          SEL_PEND:   rdData = pendArr[b];
          SEL_LEVEL:  rdData = levelArr[b];
          default:    rdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import edge_irq_pkg::*;
#(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_WIDTH = 32,
  localparam int NUM_LINES  = NUM_BANKS * BANK_WIDTH,
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W     = BANK_IDX_W + SEL_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [BANK_WIDTH-1:0] regWrData,
  output logic [BANK_WIDTH-1:0] regRdData,
  output logic [NUM_LINES-1:0]  irqPulse
);

  bankStb_t [NUM_BANKS-1:0] bankStb;
  logic [BANK_IDX_W-1:0]    rdBank;
  regSel_e                  rdSel;
  logic                     rdHit;

  edge_irq_ctrl_ctl #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_IDX_W (BANK_IDX_W),
    .ADDR_W     (ADDR_W)
  ) ctl_i (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .bankStb (bankStb),
    .rdBank  (rdBank),
    .rdSel   (rdSel),
    .rdHit   (rdHit)
  );

  edge_irq_ctrl_dp #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_WIDTH (BANK_WIDTH),
    .BANK_IDX_W (BANK_IDX_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .bankStb  (bankStb),
    .wrData   (regWrData),
    .rdBank   (rdBank),
    .rdSel    (rdSel),
    .rdHit    (rdHit),
    .rdData   (regRdData),
    .irqPulse (irqPulse)
  );

endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
  parameter int NUM_BANKS  = 2,
  parameter int BANK_WIDTH = 32,
  localparam int NUM_LINES  = NUM_BANKS * BANK_WIDTH,
  localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W     = BANK_IDX_W + 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_LINES-1:0]  lineIn,
  input logic [ADDR_W-1:0]     regAddr,
  input logic                  regWrEn,
  input logic [BANK_WIDTH-1:0] regWrData,
  input logic [BANK_WIDTH-1:0] regRdData,
  input logic [NUM_LINES-1:0]  irqPulse
);

  // Shadow of the selects, rebuilt from the write port only
  logic [NUM_LINES-1:0] shEnable, shRise, shFall, shLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shEnable <= '0;
      shRise   <= '0;
      shFall   <= '0;
      shLevel  <= '0;
    end else begin
      shLevel <= lineIn;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (regWrEn && int'(regAddr[ADDR_W-1:3]) == b) begin
          if (regAddr[2:0] == 3'd0) shEnable[b*BANK_WIDTH +: BANK_WIDTH] <= regWrData;
          if (regAddr[2:0] == 3'd1) shRise[b*BANK_WIDTH +: BANK_WIDTH]   <= regWrData;
          if (regAddr[2:0] == 3'd2) shFall[b*BANK_WIDTH +: BANK_WIDTH]   <= regWrData;
        end
      end
    end
  end

  // R5
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & ~$past(shEnable)) == '0);

  // R3
  no_change_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & ~$past(lineIn ^ shLevel)) == '0);

  // R8
  rise_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & $past(lineIn & ~shLevel & ~shRise)) == '0);

  // R8
  fall_needs_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & $past(~lineIn & shLevel & ~shFall)) == '0);

  // R12
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & $past(irqPulse) & ~$past(lineIn ^ shLevel)) == '0);

endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(
  .NUM_BANKS  (NUM_BANKS),
  .BANK_WIDTH (BANK_WIDTH)
) chk_i (.*);

// File: tb/edge_irq_ctrl_tb_top.sv
module edge_irq_ctrl_tb_top;

  localparam int NB = 2;
  localparam int BW = 32;
  localparam int NL = NB * BW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NL-1:0] lineVec = '0;
  logic [3:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [BW-1:0] regWrData = '0;
  logic [BW-1:0] regRdData;
  logic [NL-1:0] irqPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  edge_irq_ctrl #(.NUM_BANKS(NB), .BANK_WIDTH(BW)) dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineVec), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqPulse(irqPulse)
  );

  task automatic check(input bit ok, input string req, input logic [NL-1:0] act,
                       input logic [NL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] addr(input int bank, input int sel);
    return 4'((bank << 3) | sel);
  endfunction

  task automatic wr(input int bank, input int sel, input logic [BW-1:0] d);
    @(negedge clk);
    regAddr = addr(bank, sel); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int bank, input int sel, output logic [BW-1:0] d);
    regAddr = addr(bank, sel);
    #1 d = regRdData;
  endtask

  function automatic logic [NL-1:0] bitOf(input int n);
    return NL'(1) << n;
  endfunction

  // set a line, then check the pulse in the cycle after the edge and its end
  task automatic edgeCheck(input int n, input logic v, input bit expPulse, input string req);
    @(negedge clk);
    lineVec[n] = v;
    @(negedge clk);
    check(irqPulse == (expPulse ? bitOf(n) : '0), req, irqPulse, expPulse ? bitOf(n) : '0);
    @(negedge clk);
    check(irqPulse == '0, "R12 pulse ends", irqPulse, '0);
  endtask

  task automatic pendCheck(input int bank, input logic [BW-1:0] exp, input string req);
    logic [BW-1:0] d;
    rd(bank, 4, d);
    check(d == exp, req, NL'(d), NL'(exp));
  endtask

  task automatic t_reset();
    logic [BW-1:0] d;
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 6; s++) begin
        rd(b, s, d);
        check(d == '0, "R1 reg zero", NL'(d), '0);
      end
    check(irqPulse == '0, "R1 pulse zero", irqPulse, '0);
  endtask

  task automatic t_map();
    logic [BW-1:0] d;
    wr(0, 3, 32'hA5A5_0F0F);
    rd(0, 3, d);
    check(d == 32'hA5A5_0F0F, "R2 soft word", NL'(d), NL'(32'hA5A5_0F0F));
    wr(0, 5, 32'hFFFF_FFFF);
    rd(0, 5, d);
    check(d == '0, "R2 level read-only", NL'(d), '0);
    rd(1, 6, d);
    check(d == '0, "R2 code 6 zero", NL'(d), '0);
    check(irqPulse == '0, "R2 soft no effect", irqPulse, '0);
  endtask

  task automatic t_rise();
    logic [BW-1:0] d;
    wr(1, 0, 32'h100); wr(1, 1, 32'h100);
    edgeCheck(40, 1'b1, 1, "R6 rise pulse");
    pendCheck(1, 32'h100, "R12 pending persists");
    rd(1, 5, d);
    check(d[8] == 1'b1, "R2 line40 bank1 bit8", NL'(d), NL'(32'h100));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(irqPulse == '0, "R3 steady high", irqPulse, '0);
    end
    wr(1, 4, 32'h100);
    pendCheck(1, 32'h0, "R10 clear");
  endtask

  task automatic t_fall();
    wr(0, 0, 32'h8); wr(0, 2, 32'h8);
    edgeCheck(3, 1'b1, 0, "R8 rise with fall select");
    edgeCheck(3, 1'b0, 1, "R7 fall pulse");
    pendCheck(0, 32'h8, "R7 pending");
    wr(0, 4, 32'h8);
  endtask

  task automatic t_masked();
    logic [BW-1:0] d;
    wr(0, 1, 32'h20); wr(0, 2, 32'h28);
    edgeCheck(5, 1'b1, 0, "R5 masked rise");
    pendCheck(0, 32'h0, "R5 masked pending");
    rd(0, 5, d);
    check(d[5] == 1'b1, "R4 level tracked masked", NL'(d), NL'(32'h20));
    wr(0, 0, 32'h28);
    @(negedge clk);
    check(irqPulse == '0, "R4 enable while high", irqPulse, '0);
    edgeCheck(5, 1'b0, 1, "R4 fall after enable");
    wr(0, 4, 32'h20);
  endtask

  task automatic t_wrong();
    wr(1, 0, 32'h8000_0100);
    edgeCheck(63, 1'b1, 0, "R8 no select rise");
    edgeCheck(63, 1'b0, 0, "R8 no select fall");
    wr(1, 2, 32'h8000_0000);
    edgeCheck(63, 1'b1, 0, "R8 rise with fall only");
    wr(1, 2, 32'h0); wr(1, 1, 32'h8000_0100);
    edgeCheck(63, 1'b0, 0, "R8 fall with rise only");
    pendCheck(1, 32'h0, "R8 no pending");
  endtask

  task automatic t_both();
    wr(1, 2, 32'h8000_0000);
    edgeCheck(63, 1'b1, 1, "R9 rise");
    edgeCheck(63, 1'b0, 1, "R9 fall");
    pendCheck(1, 32'h8000_0000, "R9 pending");
  endtask

  task automatic t_w1c();
    edgeCheck(40, 1'b0, 0, "R8 line40 fall no select");
    edgeCheck(40, 1'b1, 1, "R6 line40 rise");
    pendCheck(1, 32'h8000_0100, "R10 two pending");
    wr(1, 4, 32'h0);
    pendCheck(1, 32'h8000_0100, "R10 write zero keeps");
    wr(1, 4, 32'h100);
    pendCheck(1, 32'h8000_0000, "R10 clear one");
  endtask

  task automatic t_collide();
    edgeCheck(40, 1'b0, 0, "R8 line40 fall again");
    @(negedge clk);
    lineVec[40] = 1'b1;
    regAddr = addr(1, 4); regWrData = 32'h8000_0100; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    check(irqPulse == bitOf(40), "R11 pulse on collide", irqPulse, bitOf(40));
    pendCheck(1, 32'h100, "R11 edge beats clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_masked();
    t_wrong();
    t_both();
    t_w1c();
    t_collide();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule